// File: doc/BRIEF.md
# Timer Event Capture and Interrupt Unit

This block sits beside a free-running 64-bit time counter and turns things that happen relative to that time into flagged events and one interrupt line. Two asynchronous trigger inputs are synchronized, and on a selectable edge each one copies the current time into its own 64-bit stamp register. Two 64-bit alarm registers are compared against the time every cycle: an equal value flags an event and drives a one-cycle pulse on an alarm pin whose active level is programmable. Three strobes from a periodic pulse generator are recorded as events as well.

All seven events share one 32-bit event word. Software clears a bit by writing a one to it, and a write of zero to a bit leaves it as it is. A mask word with the same bit layout selects which events reach the interrupt output. Software reaches the registers through a plain write strobe and read strobe with a word address. By convention the first alarm arms the pulse generators and the second alarm is left to the user. The hardware treats both alarms in the same way.

Each trigger channel runs a two-state level tracker with the states TRG_LOW and TRG_HIGH. The transition TRG_LOW to TRG_HIGH is taken when the synchronized level becomes 1, and TRG_HIGH to TRG_LOW when it becomes 0. A capture fires on the first of these transitions when rising-edge mode is selected, and on the second when falling-edge mode is selected.

Top module: `time_event_hub`

## Requirements
- R1: After reset, the control, event and mask words read 0, both stamps read 0, both alarm registers read all ones, `irq` is 0 and both alarm pins are 0.
- R2: A trigger edge on `trig_in[k]` that passes the two-flop synchronizer does two things on the third rising clock edge after the input changes. It stores the value that `time_now` held in the cycle just before that edge into stamp k. It also sets event bit 24 for k=0 or bit 25 for k=1.
- R3: Control bit 8 selects the edge for trigger 0 and control bit 9 selects it for trigger 1. A value of 0 means rising and 1 means falling. The edge that is not selected leaves the stamp unchanged and sets no event.
- R4: A new selected edge overwrites the stamp even while that channel's event bit is still set.
- R5: When `time_now` equals alarm register k, event bit 16 for k=0 or bit 17 for k=1 is set at the next clock edge.
- R6: For the one cycle after a match, `alarm_pin[k]` is the inverse of its polarity bit. At all other times the pin equals its polarity bit. The polarity bit is control bit 31 for k=0 and bit 30 for k=1.
- R7: A strobe on `pulse_in[p]` sets event bit 7-p, so bits 7, 6 and 5 belong to strobes 0, 1 and 2.
- R8: Writing the event word clears each event bit written with a 1 and leaves each bit written with a 0 unchanged.
- R9: An event source that is active in the same cycle as a clearing write to its bit leaves the bit set.
- R10: The mask word stores only the seven implemented positions, so a write of all ones reads back 0x030300E0. `irq` is the OR of event AND mask, registered, and it follows the event word one cycle later.
- R11: The word addresses are: 0 control, 1 event, 2 mask, 4/5 alarm 0 low/high, 6/7 alarm 1 low/high, 8/9 stamp 0 low/high, 10/11 stamp 1 low/high. Only bits 31, 30, 9 and 8 of the control word are stored. The stamps are read-only, and a write to a stamp address has no effect. `rdata` shows the addressed word while `rd_en` is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| time_now | input | 64 | Current time from the time counter |
| trig_in | input | 2 | Asynchronous external trigger inputs |
| pulse_in | input | 3 | One-cycle strobes from the pulse generator |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Masked interrupt, registered |
| alarm_pin | output | 2 | Alarm pulse outputs with programmable active level |

## Verification
If a trigger tracker holds the wrong state, a selected edge is missed or an extra capture appears. This shows up in the event word and in the stamp three clock edges after the input changes. An alarm comparator or pin register that is wrong shows on `alarm_pin` in the cycle right after the match, and in the event bit at the same edge. A wrong event or mask bit reaches `irq` one cycle later. Because the bench checks set-versus-clear collisions and every mask pattern, a fault in the clear logic or the interrupt reduction also shows on `irq` within two cycles.

// File: rtl/tec_pkg.sv
package tec_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int N_TRIG  = 2;
    localparam int N_ALARM = 2;
    localparam int N_PULSE = 3;

    // event bit positions (shared with the mask word)
    localparam int TRIG_EVT_LSB  = 24;
    localparam int ALARM_EVT_LSB = 16;
    localparam int PULSE_EVT_TOP = 7;

    // control bit positions
    localparam int TRIG_EDGE_LSB = 8;
    localparam int ALARM_POL_TOP = 31;

    // word addresses
    localparam int OFS_CTRL       = 0;
    localparam int OFS_EVENT      = 1;
    localparam int OFS_MASK       = 2;
    localparam int OFS_ALARM_BASE = 4;
    localparam int OFS_STAMP_BASE = 8;

    typedef enum logic {
        TRG_LOW  = 1'b0,
        TRG_HIGH = 1'b1
    } trg_state_e;

    function automatic logic [DATA_W-1:0] evt_impl_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int t = 0; t < N_TRIG; t++)  m[TRIG_EVT_LSB + t]  = 1'b1;
        for (int a = 0; a < N_ALARM; a++) m[ALARM_EVT_LSB + a] = 1'b1;
        for (int p = 0; p < N_PULSE; p++) m[PULSE_EVT_TOP - p] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_impl_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int t = 0; t < N_TRIG; t++)  m[TRIG_EDGE_LSB + t] = 1'b1;
        for (int a = 0; a < N_ALARM; a++) m[ALARM_POL_TOP - a] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] EVT_IMPL  = evt_impl_bits();
    localparam logic [DATA_W-1:0] CTRL_IMPL = ctrl_impl_bits();
endpackage

// File: rtl/tec_trig_channel.sv
module tec_trig_channel
    import tec_pkg::*;
#(
    parameter int TIME_W      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_async,
    input  logic              fall_sel,
    input  logic [TIME_W-1:0] time_now,
    output logic              capture,
    output logic [TIME_W-1:0] stamp
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    trg_state_e             state_q;
    trg_state_e             state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], trig_async};
    end

    assign level = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRG_LOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRG_LOW:  if (level)  state_d = TRG_HIGH;
            TRG_HIGH: if (!level) state_d = TRG_LOW;
        endcase
    end

    // outputs: capture on the transition that matches the selected edge
    always_comb begin
        capture = 1'b0;
        unique case (state_q)
            TRG_LOW:  capture = level & ~fall_sel;
            TRG_HIGH: capture = ~level & fall_sel;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stamp <= '0;
        else if (capture) stamp <= time_now;
    end
endmodule

// File: rtl/tec_alarm.sv
module tec_alarm #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TIME_W-1:0] alarm_val,
    input  logic              active_low,
    output logic              hit,
    output logic              pin
);
    logic hit_q;

    assign hit = (time_now == alarm_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

    assign pin = hit_q ^ active_low;
endmodule

// File: rtl/tec_event_block.sv
module tec_event_block
    import tec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_vec,
    input  logic              clr_we,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] evt_q,
    output logic [DATA_W-1:0] mask_q,
    output logic              irq
);
    logic [DATA_W-1:0] clr_vec;

    assign clr_vec = clr_we ? (wdata & EVT_IMPL) : '0;

    // a source active in the clearing cycle wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= ((evt_q & ~clr_vec) | set_vec) & EVT_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata & EVT_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(evt_q & mask_q);
    end
endmodule

// File: rtl/time_event_hub.sv
module time_event_hub
    import tec_pkg::*;
#(
    parameter int TIME_W      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TIME_W-1:0]    time_now,
    input  logic [N_TRIG-1:0]    trig_in,
    input  logic [N_PULSE-1:0]   pulse_in,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 irq,
    output logic [N_ALARM-1:0]   alarm_pin
);
    localparam int HI_W = TIME_W - DATA_W;

    logic [DATA_W-1:0] ctrl_q;
    logic [TIME_W-1:0] alarm_q [N_ALARM];
    logic [TIME_W-1:0] stamp_w [N_TRIG];
    logic [N_TRIG-1:0] cap_w;
    logic [N_ALARM-1:0] hit_w;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] evt_w;
    logic [DATA_W-1:0] mask_w;
    logic [DATA_W-1:0] rd_mux;
    logic              wr_ctrl;
    logic              wr_evt;
    logic              wr_mask;

    assign wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
    assign wr_evt  = wr_en && (addr == ADDR_W'(OFS_EVENT));
    assign wr_mask = wr_en && (addr == ADDR_W'(OFS_MASK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata & CTRL_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_ALARM; k++) alarm_q[k] <= '1;
        end else if (wr_en) begin
            for (int k = 0; k < N_ALARM; k++) begin
                if (addr == ADDR_W'(OFS_ALARM_BASE + 2 * k))
                    alarm_q[k][DATA_W-1:0] <= wdata;
                if (addr == ADDR_W'(OFS_ALARM_BASE + 2 * k + 1))
                    alarm_q[k][TIME_W-1:DATA_W] <= wdata[HI_W-1:0];
            end
        end
    end

    for (genvar k = 0; k < N_TRIG; k++) begin : g_trig
        tec_trig_channel #(
            .TIME_W     (TIME_W),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_trg (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig_async(trig_in[k]),
            .fall_sel  (ctrl_q[TRIG_EDGE_LSB + k]),
            .time_now  (time_now),
            .capture   (cap_w[k]),
            .stamp     (stamp_w[k])
        );
    end

    for (genvar k = 0; k < N_ALARM; k++) begin : g_alarm
        tec_alarm #(
            .TIME_W(TIME_W)
        ) u_alm (
            .clk       (clk),
            .rst_n     (rst_n),
            .time_now  (time_now),
            .alarm_val (alarm_q[k]),
            .active_low(ctrl_q[ALARM_POL_TOP - k]),
            .hit       (hit_w[k]),
            .pin       (alarm_pin[k])
        );
    end

    always_comb begin
        set_vec = '0;
        for (int k = 0; k < N_TRIG; k++)  set_vec[TRIG_EVT_LSB + k]  = cap_w[k];
        for (int k = 0; k < N_ALARM; k++) set_vec[ALARM_EVT_LSB + k] = hit_w[k];
        for (int p = 0; p < N_PULSE; p++) set_vec[PULSE_EVT_TOP - p] = pulse_in[p];
    end

    tec_event_block u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_we (wr_evt),
        .mask_we(wr_mask),
        .wdata  (wdata),
        .evt_q  (evt_w),
        .mask_q (mask_w),
        .irq    (irq)
    );

    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(OFS_CTRL))  rd_mux = ctrl_q;
        if (addr == ADDR_W'(OFS_EVENT)) rd_mux = evt_w;
        if (addr == ADDR_W'(OFS_MASK))  rd_mux = mask_w;
        for (int k = 0; k < N_ALARM; k++) begin
            if (addr == ADDR_W'(OFS_ALARM_BASE + 2 * k))
                rd_mux = alarm_q[k][DATA_W-1:0];
            if (addr == ADDR_W'(OFS_ALARM_BASE + 2 * k + 1))
                rd_mux = DATA_W'(alarm_q[k] >> DATA_W);
        end
        for (int k = 0; k < N_TRIG; k++) begin
            if (addr == ADDR_W'(OFS_STAMP_BASE + 2 * k))
                rd_mux = stamp_w[k][DATA_W-1:0];
            if (addr == ADDR_W'(OFS_STAMP_BASE + 2 * k + 1))
                rd_mux = DATA_W'(stamp_w[k] >> DATA_W);
        end
    end

    assign rdata = rd_en ? rd_mux : '0;
endmodule

// File: rtl/tec_checker.sv
module tec_checker #(
    parameter int TIME_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIME_W-1:0] time_now,
    input logic [2:0]        pulse_in,
    input logic [31:0]       evt,
    input logic [31:0]       mask,
    input logic              irq,
    input logic [1:0]        cap,
    input logic [TIME_W-1:0] stamp_a,
    input logic [TIME_W-1:0] stamp_b,
    input logic [TIME_W-1:0] alarm_a,
    input logic [TIME_W-1:0] alarm_b,
    input logic [1:0]        alarm_pin,
    input logic [31:0]       ctrl
);
    // R2
    trig_a_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap[0] |=> (evt[24] && stamp_a == $past(time_now)));

    // R2
    trig_b_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap[1] |=> (evt[25] && stamp_b == $past(time_now)));

    // R5
    alarm_a_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (time_now == alarm_a) |=> evt[16]);

    // R5
    alarm_b_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (time_now == alarm_b) |=> evt[17]);

    // R6
    alarm_b_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (time_now == alarm_b) |=> (alarm_pin[1] != ctrl[30]));

    // R9
    pulse_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_in[0] |=> evt[7]);

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & mask)) |=> irq);

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(evt & mask)) |=> !irq);
endmodule

bind time_event_hub tec_checker #(.TIME_W(TIME_W)) u_tec_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .time_now (time_now),
    .pulse_in (pulse_in),
    .evt      (evt_w),
    .mask     (mask_w),
    .irq      (irq),
    .cap      (cap_w),
    .stamp_a  (stamp_w[0]),
    .stamp_b  (stamp_w[1]),
    .alarm_a  (alarm_q[0]),
    .alarm_b  (alarm_q[1]),
    .alarm_pin(alarm_pin),
    .ctrl     (ctrl_q)
);

// File: tb/tb_time_event_hub.sv
`timescale 1ns/1ps
module tb_time_event_hub;
    localparam logic [31:0] IMPL = 32'h0303_00E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tnow = 64'h0000_0001_FFFF_FFA0;
    logic [1:0]  trig_in = '0;
    logic [2:0]  pulse_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [1:0]  alarm_pin;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) tnow <= tnow + 64'd1;

    time_event_hub dut (
        .clk(clk), .rst_n(rst_n), .time_now(tnow), .trig_in(trig_in),
        .pulse_in(pulse_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .alarm_pin(alarm_pin)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic rd64(input logic [3:0] a, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(a, lo);
        rd(a + 4'd1, hi);
        d = {hi, lo};
    endtask

    task automatic pulse(input int p);
        @(negedge clk);
        pulse_in[p] = 1'b1;
        @(negedge clk);
        pulse_in = '0;
    endtask

    task automatic drive_trig(input int ch, input logic v, output logic [63:0] t);
        @(negedge clk);
        trig_in[ch] = v;
        t = tnow;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] q, t, old;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 pins", alarm_pin, 0);
        rd(0, d); chk("R1 ctrl", d, 0);
        rd(1, d); chk("R1 event", d, 0);
        rd(2, d); chk("R1 mask", d, 0);
        rd64(8, q);  chk("R1 stamp0", q, 0);
        rd64(10, q); chk("R1 stamp1", q, 0);
        rd64(4, q);  chk("R1 alarm0", q, '1);
        rd64(6, q);  chk("R1 alarm1", q, '1);
        rd(3, d); chk("R11 unused addr", d, 0);

        // R10 mask stores only implemented bits; R11 ctrl stores only its bits
        wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R10 mask readback", d, IMPL);
        wr(2, 0);
        wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R11 ctrl readback", d, 32'hC000_0300);
        wr(0, 0);
        wr(4, 32'h1234_5678); rd(4, d); chk("R11 alarm0 lo", d, 32'h1234_5678);
        wr(4, 32'hFFFF_FFFF);

        // R7 each strobe to its bit
        for (int p = 0; p < 3; p++) begin
            pulse(p);
            rd(1, d); chk("R7 pulse event", d, 32'h1 << (7 - p));
            wr(1, 32'h1 << (7 - p));
            rd(1, d); chk("R8 single clear", d, 0);
        end

        // R8 every clear pattern over the three pulse bits
        for (int w = 0; w < 8; w++) begin
            @(negedge clk); pulse_in = 3'b111;
            @(negedge clk); pulse_in = '0;
            wr(1, 32'(w) << 5);
            rd(1, d); chk("R8 w1c pattern", d, (~(32'(w) << 5)) & 32'hE0);
            wr(1, IMPL);
        end

        // R10 irq under every mask pattern for each strobe
        for (int p = 0; p < 3; p++) begin
            for (int m = 0; m < 8; m++) begin
                logic [2:0] mb;
                mb = 3'(m);
                wr(2, 32'(m) << 5);
                wr(1, IMPL);
                @(negedge clk);
                chk("R10 irq idle", irq, 0);
                pulse(p);
                @(negedge clk);
                chk("R10 irq masked", irq, mb[2 - p]);
            end
        end
        wr(2, 0); wr(1, IMPL);
        @(negedge clk);

        // R9 set wins over same-cycle clear
        pulse(1);
        @(negedge clk);
        wr_en = 1'b1; addr = 1; wdata = 32'h40; pulse_in[1] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; pulse_in = '0;
        rd(1, d); chk("R9 set wins", d, 32'h40);
        wr(1, 32'h40);
        rd(1, d); chk("R9 plain clear", d, 0);

        // R2 R3 triggers, both edge modes, both channels
        for (int ch = 0; ch < 2; ch++) begin
            logic [3:0] sa;
            sa = 4'(8 + 2 * ch);
            // rising mode
            wr(0, 32'h1 << (8 + ch));
            wr(0, 0);
            wr(1, IMPL);
            drive_trig(ch, 1'b1, t);
            rd(1, d); chk("R2 rising event", d, 32'h1 << (24 + ch));
            rd64(sa, q); chk("R2 rising stamp", q, t + 64'd2);
            old = q;
            wr(1, IMPL);
            drive_trig(ch, 1'b0, t);
            rd(1, d); chk("R3 falling ignored event", d, 0);
            rd64(sa, q); chk("R3 falling ignored stamp", q, old);
            // falling mode
            wr(0, 32'h1 << (8 + ch));
            drive_trig(ch, 1'b1, t);
            rd(1, d); chk("R3 rising ignored event", d, 0);
            rd64(sa, q); chk("R3 rising ignored stamp", q, old);
            drive_trig(ch, 1'b0, t);
            rd(1, d); chk("R3 falling event", d, 32'h1 << (24 + ch));
            rd64(sa, q); chk("R3 falling stamp", q, t + 64'd2);
            wr(1, IMPL);
            wr(0, 0);
        end

        // R4 overwrite while pending
        drive_trig(0, 1'b1, t);
        drive_trig(0, 1'b0, t);
        drive_trig(0, 1'b1, t);
        rd(1, d); chk("R4 still pending", d, 32'h0100_0000);
        rd64(8, q); chk("R4 overwritten stamp", q, t + 64'd2);
        // R11 stamp write ignored
        wr(8, 32'hDEAD_BEEF);
        rd64(8, old); chk("R11 stamp read-only", old, q);
        drive_trig(0, 1'b0, t);
        wr(1, IMPL);

        // R5 R6 alarms, both polarities
        wr(2, IMPL);
        for (int k = 0; k < 2; k++) begin
            for (int pol = 0; pol < 2; pol++) begin
                logic [63:0] target;
                logic [1:0] expidle, expact;
                wr(0, 32'(pol) << (31 - k));
                expidle = 2'(pol) << k;
                expact = expidle ^ (2'b1 << k);
                @(negedge clk);
                chk("R6 pin idle", alarm_pin, expidle);
                target = tnow + 64'd40;
                wr(4'(4 + 2 * k), target[31:0]);
                wr(4'(5 + 2 * k), target[63:32]);
                wr(1, IMPL);
                @(negedge clk);
                chk("R10 irq before alarm", irq, 0);
                while (tnow != target) @(negedge clk);
                chk("R6 pin before match", alarm_pin, expidle);
                @(negedge clk);
                chk("R6 pin active", alarm_pin, expact);
                rd(1, d);
                chk("R5 alarm event", d, 32'h1 << (16 + k));
                chk("R6 pin one cycle", alarm_pin, expidle);
                chk("R10 irq from alarm", irq, 1);
                wr(4'(5 + 2 * k), 32'hFFFF_FFFF);
                wr(4'(4 + 2 * k), 32'hFFFF_FFFF);
                wr(1, IMPL);
                @(negedge clk);
            end
        end
        wr(0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule